// File: doc/BRIEF.md
# Programmable-Length Loop-Filter Counter

This block is the loop-filter stage of a first-order all-digital phase-locked loop. It holds an up/down count. On each filter-clock strobe, while it is enabled, the count moves by one. A direction input, normally fed from the phase detector, sets whether that step is up or down. The counter wraps at a power-of-two length, and a 4-bit length code picks that length at run time. Each wrap is reported as a one-cycle pulse. An upward wrap pulses `carry_o` and a downward wrap pulses `borrow_o`. A downstream pulse add/delete stage uses these pulses to correct the loop's output frequency.

A short counter gives a wide loop bandwidth and fast lock, and a long counter gives a narrow bandwidth. The code can change while the loop runs. Any count bits above the new length are dropped on the next strobe, so the count always stays inside the selected range.

The filter clock is a clock-enable strobe in the single system clock domain. The block has one register stage from strobe to pulse.

Top module: `loop_filter_counter`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, the count is 0 and `carry_o` and `borrow_o` are low.
- R2: While `mod_code_i` is 0, no strobe changes the count and neither pulse is raised. When the code becomes non-zero again, counting resumes from the held value.
- R3: A code n in 1..15 sets a counter length of n+2 bits, which is a modulus of 2^(n+2). Starting from 0 and counting up, the first carry comes on up-strobe number 2^(n+2), and the next carry comes 2^(n+2) strobes later.
- R4: An up step (`down_i`=0) from count modulus-1 to 0 sets `carry_o` high for exactly the one clock cycle after the strobe edge.
- R5: A down step (`down_i`=1) from count 0 to modulus-1 sets `borrow_o` high for exactly the one clock cycle after the strobe edge.
- R6: A strobe that arrives while `en_i` is low is ignored. The count and both pulses are unaffected.
- R7: The count changes only in a cycle with `step_i` high. Without a strobe, no pulse appears.
- R8: After a code change, the next accepted strobe first drops the count bits above the new length and then steps the count. The stored count is never outside the range of the code in force at the last accepted strobe.
- R9: `carry_o` and `borrow_o` are never high together, and neither one is high in two cycles in a row.
- R10: Up and down steps cancel: n up strobes followed by n down strobes bring the count back to its earlier value, and no wrap is reported if no boundary is crossed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Filter-clock strobe, one step per high cycle |
| en_i | input | 1 | Counting enable, active high |
| down_i | input | 1 | Step direction: 0 up, 1 down |
| mod_code_i | input | 4 | Length code: 0 disables counting, n gives modulus 2^(n+2) |
| carry_o | output | 1 | One-cycle pulse on an upward wrap |
| borrow_o | output | 1 | One-cycle pulse on a downward wrap |

## Verification
The assertions check these properties on every cycle:
- each pulse follows an accepted strobe in the matching direction;
- a zero code produces no pulse;
- the two pulses never overlap and never last longer than one cycle;
- the count stays still when no step is accepted;
- the count stays inside the range of the code in force at the last accepted strobe.

Some properties span many strobes and only the bench's scenarios can show them. These are the exact wrap period for each code, the count held across disabled spans, the masking of a large count when the code shrinks, and the cancellation of up and down steps.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
  localparam int unsigned CODE_W     = 4;
  localparam int unsigned STAGE_BASE = 2;
  localparam int unsigned CNT_W      = (1 << CODE_W) - 1 + STAGE_BASE;

  typedef enum logic [1:0] {
    WRAP_NONE = 2'd0,
    WRAP_UP   = 2'd1,
    WRAP_DOWN = 2'd2
  } wrap_e;
endpackage

// File: rtl/lfc_len_decode.sv
module lfc_len_decode #(
  parameter int unsigned CODE_W     = 4,
  parameter int unsigned STAGE_BASE = 2,
  parameter int unsigned CNT_W      = 17
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [CNT_W-1:0]  mask_o,
  output logic              active_o
);
  assign active_o = |code_i;

  // bit i belongs to the counter when i < code + STAGE_BASE
  for (genvar i = 0; i < CNT_W; i++) begin : g_mask
    assign mask_o[i] = active_o && (i < (int'(code_i) + int'(STAGE_BASE)));
  end
endmodule

// File: rtl/lfc_count_core.sv
module lfc_count_core
  import lfc_pkg::*;
#(
  parameter int unsigned CNT_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             down_i,
  input  logic [CNT_W-1:0] mask_i,
  output wrap_e            wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_m;
  logic             at_top, at_bot;

  assign cnt_m  = cnt_q & mask_i;
  assign at_top = (cnt_m == mask_i);
  assign at_bot = (cnt_m == '0);

  always_comb begin
    cnt_d  = cnt_q;
    wrap_o = WRAP_NONE;
    if (adv_i) begin
      if (down_i) begin
        if (at_bot) begin
          cnt_d  = mask_i;
          wrap_o = WRAP_DOWN;
        end else begin
          cnt_d = cnt_m - CNT_W'(1);
        end
      end else begin
        if (at_top) begin
          cnt_d  = '0;
          wrap_o = WRAP_UP;
        end else begin
          cnt_d = cnt_m + CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assert_count_in_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> ((cnt_q & ~$past(mask_i)) == '0));

  assert_count_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(cnt_q));
endmodule

// File: rtl/lfc_pulse_out.sv
module lfc_pulse_out
  import lfc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  wrap_e wrap_i,
  output logic  carry_o,
  output logic  borrow_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      carry_o  <= 1'b0;
      borrow_o <= 1'b0;
    end else begin
      carry_o  <= (wrap_i == WRAP_UP);
      borrow_o <= (wrap_i == WRAP_DOWN);
    end
  end

  assert_pulse_exclusive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({carry_o, borrow_o}));

  assert_carry_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |=> !carry_o);

  assert_borrow_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    borrow_o |=> !borrow_o);
endmodule

// File: rtl/loop_filter_counter.sv
module loop_filter_counter
  import lfc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              en_i,
  input  logic              down_i,
  input  logic [CODE_W-1:0] mod_code_i,
  output logic              carry_o,
  output logic              borrow_o
);
  logic [CNT_W-1:0] mask;
  logic             active;
  logic             adv;
  wrap_e            wrap;

  lfc_len_decode #(
    .CODE_W    (CODE_W),
    .STAGE_BASE(STAGE_BASE),
    .CNT_W     (CNT_W)
  ) u_dec (
    .code_i  (mod_code_i),
    .mask_o  (mask),
    .active_o(active)
  );

  assign adv = step_i && en_i && active;

  lfc_count_core #(.CNT_W(CNT_W)) u_core (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (adv),
    .down_i(down_i),
    .mask_i(mask),
    .wrap_o(wrap)
  );

  lfc_pulse_out u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wrap_i  (wrap),
    .carry_o (carry_o),
    .borrow_o(borrow_o)
  );

  assert_carry_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |-> $past(step_i && en_i && !down_i && (mod_code_i != '0)));

  assert_borrow_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    borrow_o |-> $past(step_i && en_i && down_i && (mod_code_i != '0)));

  assert_zero_code_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_code_i == '0) |=> !(carry_o || borrow_o));

  assert_no_enable_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !(carry_o || borrow_o));
endmodule

// File: tb/sim_loop_filter_counter.sv
`timescale 1ns/1ps
module sim_loop_filter_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step = 1'b0;
  logic       en = 1'b0;
  logic       dn = 1'b0;
  logic [3:0] code = 4'd0;
  logic       carry, borrow;
  int         total = 0;
  int         bad = 0;
  int         both_seen = 0;

  always #2 clk = ~clk;

  loop_filter_counter u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .step_i    (step),
    .en_i      (en),
    .down_i    (dn),
    .mod_code_i(code),
    .carry_o   (carry),
    .borrow_o  (borrow)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [3:0] c);
    @(negedge clk);
    rst_n = 1'b0; step = 1'b0; en = 1'b1; dn = 1'b0; code = c;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic strobe(input logic d, output logic c, output logic b);
    dn = d; step = 1'b1;
    @(negedge clk);
    step = 1'b0;
    c = carry; b = borrow;
    if (c && b) both_seen++;
  endtask

  task automatic run(input int n, input logic d, output int fc, output int fb,
                     output int nc, output int nb);
    logic c, b;
    fc = 0; fb = 0; nc = 0; nb = 0;
    for (int i = 1; i <= n; i++) begin
      strobe(d, c, b);
      if (c) begin nc++; if (fc == 0) fc = i; end
      if (b) begin nb++; if (fb == 0) fb = i; end
    end
  endtask

  task automatic t_reset();
    logic c, b;
    @(negedge clk);
    rst_n = 1'b0; code = 4'd1; en = 1'b1;
    @(negedge clk);
    check(!carry && !borrow, "R1", "pulses low in reset", {carry, borrow}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!carry && !borrow, "R1", "pulses low after reset", {carry, borrow}, 0);
    strobe(1'b1, c, b);
    check(b, "R1", "count 0 so first down wraps", b, 1);
  endtask

  task automatic t_modulus();
    int fc, fb, nc, nb, m;
    int codes[4] = '{1, 2, 3, 5};
    foreach (codes[k]) begin
      do_reset(4'(codes[k]));
      m = 1 << (codes[k] + 2);
      run(2 * m, 1'b0, fc, fb, nc, nb);
      check(fc == m, "R3", "first carry strobe", fc, m);
      check(nc == 2, "R3", "carries in two periods", nc, 2);
      check(nb == 0, "R4", "no borrow counting up", nb, 0);
    end
  endtask

  task automatic t_long();
    logic c, b;
    for (int k = 14; k <= 15; k++) begin
      do_reset(4'(k));
      strobe(1'b1, c, b);
      check(b && !c, "R5", "down wrap at long length", b, 1);
      strobe(1'b0, c, b);
      check(c && !b, "R3", "top of long length wraps up", c, 1);
    end
  endtask

  task automatic t_borrow();
    int fc, fb, nc, nb;
    do_reset(4'd2);
    run(32, 1'b1, fc, fb, nc, nb);
    check(fb == 1, "R5", "first borrow strobe", fb, 1);
    check(nb == 2, "R5", "borrows over 32 down strobes", nb, 2);
    check(nc == 0, "R5", "no carry counting down", nc, 0);
  endtask

  task automatic t_disable();
    int fc, fb, nc, nb, nc2, nb2;
    do_reset(4'd1);
    run(3, 1'b0, fc, fb, nc, nb);
    code = 4'd0;
    run(20, 1'b0, fc, fb, nc, nb);
    run(20, 1'b1, fc, fb, nc2, nb2);
    check(nc + nc2 + nb + nb2 == 0, "R2", "pulses with zero code", nc + nc2 + nb + nb2, 0);
    code = 4'd1;
    run(8, 1'b0, fc, fb, nc, nb);
    check(fc == 5, "R2", "count held across disable", fc, 5);
  endtask

  task automatic t_enable();
    int fc, fb, nc, nb;
    do_reset(4'd1);
    run(3, 1'b0, fc, fb, nc, nb);
    en = 1'b0;
    run(20, 1'b0, fc, fb, nc, nb);
    check(nc == 0, "R6", "carries with enable low", nc, 0);
    en = 1'b1;
    run(8, 1'b0, fc, fb, nc, nb);
    check(fc == 5, "R6", "count held with enable low", fc, 5);
  endtask

  task automatic t_idle();
    int fc, fb, nc, nb, seen;
    do_reset(4'd1);
    run(3, 1'b0, fc, fb, nc, nb);
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (carry || borrow) seen++;
    end
    check(seen == 0, "R7", "pulses without strobe", seen, 0);
    run(8, 1'b0, fc, fb, nc, nb);
    check(fc == 5, "R7", "count held without strobe", fc, 5);
  endtask

  task automatic t_mask();
    logic c, b;
    int fc, fb, nc, nb;
    do_reset(4'd3);
    strobe(1'b1, c, b);
    check(b, "R8", "borrow to 31 at code 3", b, 1);
    code = 4'd1;
    strobe(1'b0, c, b);
    check(c, "R8", "31 masked to 7 then wraps", c, 1);
    run(8, 1'b0, fc, fb, nc, nb);
    check(fc == 8, "R8", "count in range after shrink", fc, 8);
  endtask

  task automatic t_reverse();
    logic c, b;
    int fc, fb, nc, nb;
    do_reset(4'd1);
    run(3, 1'b0, fc, fb, nc, nb);
    run(3, 1'b1, fc, fb, nc, nb);
    check(nb + nc == 0, "R10", "no wrap returning to 0", nb + nc, 0);
    strobe(1'b1, c, b);
    check(b, "R10", "back at 0 then down wraps", b, 1);
  endtask

  task automatic t_pulse();
    int fc, fb, nc, nb;
    do_reset(4'd1);
    run(8, 1'b0, fc, fb, nc, nb);
    check(fc == 8, "R4", "carry on eighth strobe", fc, 8);
    @(negedge clk);
    check(!carry, "R4", "carry one cycle wide", carry, 0);
    dn = 1'b1; step = 1'b1;
    @(negedge clk);
    step = 1'b0;
    check(borrow, "R5", "borrow at 0 after wrap", borrow, 1);
    @(negedge clk);
    check(!borrow, "R5", "borrow one cycle wide", borrow, 0);
    check(both_seen == 0, "R9", "cycles with both pulses", both_seen, 0);
  endtask

  initial begin
    t_reset();
    t_modulus();
    t_long();
    t_borrow();
    t_disable();
    t_enable();
    t_idle();
    t_mask();
    t_reverse();
    t_pulse();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule